// File: doc/BRIEF.md
# Unaligned Longword Access Splitter

This block takes one CPU data access that may sit at any byte offset and carries it out as at most two pieces, each of which stays inside a single 32-bit longword. A read rebuilds the requested value from the pieces. A write updates only the bytes that were asked for. The caller supplies the byte address, the access size, a read/write flag and the write data. It also supplies the aligned address of the following longword, already translated, so the second piece may land on an unrelated page.

Addresses with the top bit clear select a 32-bit word array inside the block. Addresses with the top bit set select register space. Each register-space piece appears on a fragment port that carries the aligned address, the lane offset, the piece length in bytes and the data. Register space only handles whole longwords. A partial register write is therefore done as a read of the longword, a merge of the new lanes, and a full write-back. A memory piece is read or merged in place in one cycle.

Pieces are issued lower address first. A one-cycle done pulse follows the last piece, and the read result is valid on `rdata` while done is high.

Top module: `lw_splitter`

## Requirements
- R1: After reset, `busy`, `done` and `frag_valid` are all low.
- R2: Size code 0 is a byte and size code 1 is a 16-bit word. A byte at any offset, a word at offset 0 or 2, and a longword (code 2) at offset 0 are each done as one piece. `done` is high in the second cycle after the accepting edge when that piece goes to memory.
- R3: A longword at offset b (address bits 1:0, b≠0) is done as two pieces. The first is 4−b bytes at the address. The second is b bytes at offset 0 of the supplied next longword address, whose low two bits are ignored. The read result is the first piece OR'd with the second piece shifted left by 8·(4−b).
- R4: On a longword write at offset b≠0, data bytes 0 to 3−b go to the first piece and the remaining b bytes go to the second.
- R5: A word at offset 1 is one 2-byte piece. A word at offset 3 is two 1-byte pieces: the low byte at the address and the high byte at offset 0 of the next longword.
- R6: A memory write changes only the bytes of the access and leaves the other lanes of each touched longword unchanged.
- R7: A register-space read piece is one fragment-port cycle with `frag_we`=0 and the aligned longword address. The block extracts the piece's lanes from `frag_rdata`, which is sampled in that cycle.
- R8: A register-space write piece shorter than 4 bytes takes two fragment-port cycles: a read, then a write of the full merged longword. A full-longword register write is a single write cycle with no read.
- R9: Pieces run strictly in address order, first piece before second. Each memory piece or register read takes one cycle, and a partial register write takes two. `done` is high for exactly one cycle, in the cycle after the last piece.
- R10: `req_valid` is ignored while `busy` is high.
- R11: Size code 3 behaves exactly like size code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start an access (accepted when not busy) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2 or 3 longword |
| req_addr | input | ADDR_W | Byte address of the access |
| req_next_addr | input | ADDR_W | Translated address of the following longword |
| req_wdata | input | 32 | Write data, right-justified |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read result, right-justified, valid with done |
| frag_valid | output | 1 | Register-space fragment cycle |
| frag_we | output | 1 | Fragment cycle is a longword write |
| frag_addr | output | ADDR_W | Aligned longword address of the fragment |
| frag_off | output | 2 | Byte lane where the piece starts |
| frag_bytes | output | 3 | Piece length in bytes (1 to 4) |
| frag_wdata | output | 32 | Longword to write (merged for partial pieces) |
| frag_rdata | input | 32 | Longword returned by register space in the same cycle |

## Verification
The bench targets accesses that cross a longword: longwords at offsets 1 to 3, a word at offset 3, and a second piece steered to a translated address that is not the next one in sequence. A design that mis-sizes a piece, or that joins the pieces with the wrong shift, returns bytes in the wrong lanes or writes into neighbouring bytes. The bench checks these neighbours on later reads. On the register side, the bench logs every fragment cycle and compares the register contents with its own byte model. A missing read-before-write, a needless read on a full-longword write, an extra bus cycle or a reversed piece order all show up in the log and in the cycle count. An intruding request during a busy access would corrupt a byte that the bench reads back afterwards.

// File: rtl/lws_pkg.sv
package lws_pkg;

    localparam int LW_BITS = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_LALT = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRAG  = 2'd1,
        ST_WBACK = 2'd2,
        ST_DONE  = 2'd3
    } state_e;

    // one piece of an access, confined to one longword
    typedef struct packed {
        logic [1:0]         off;
        logic [2:0]         nbytes;
        logic [LW_BITS-1:0] data;
    } frag_t;

    typedef struct packed {
        frag_t      f0;
        frag_t      f1;
        logic       two;
        logic [4:0] join_sh;
    } plan_t;

    function automatic logic [LW_BITS-1:0] lane_mask(input logic [2:0] n);
        if (n >= 3'd4) return '1;
        return (32'h1 << {n[1:0], 3'b000}) - 32'h1;
    endfunction

    function automatic logic [LW_BITS-1:0] lane_extract(input logic [LW_BITS-1:0] lw,
                                                        input logic [1:0] off,
                                                        input logic [2:0] n);
        return (lw >> {off, 3'b000}) & lane_mask(n);
    endfunction

    function automatic logic [LW_BITS-1:0] lane_merge(input logic [LW_BITS-1:0] lw,
                                                      input logic [1:0] off,
                                                      input logic [2:0] n,
                                                      input logic [LW_BITS-1:0] d);
        logic [LW_BITS-1:0] m;
        m = lane_mask(n) << {off, 3'b000};
        return (lw & ~m) | ((d & lane_mask(n)) << {off, 3'b000});
    endfunction

endpackage

// File: rtl/lws_planner.sv
module lws_planner
    import lws_pkg::*;
(
    input  logic [1:0]  off,
    input  logic [1:0]  size,
    input  logic [31:0] wdata,
    output plan_t       plan
);
    logic [2:0] n0;
    logic [2:0] n1;
    logic       two;

    always_comb begin
        two = 1'b0;
        n0  = 3'd1;
        n1  = 3'd0;
        case (size)
            SZ_BYTE: n0 = 3'd1;
            SZ_WORD: begin
                if (off == 2'd3) begin
                    two = 1'b1;
                    n0  = 3'd1;
                    n1  = 3'd1;
                end else begin
                    n0 = 3'd2;
                end
            end
            default: begin
                if (off == 2'd0) begin
                    n0 = 3'd4;
                end else begin
                    two = 1'b1;
                    n0  = 3'd4 - {1'b0, off};
                    n1  = {1'b0, off};
                end
            end
        endcase
    end

    // the second piece always takes the bytes above the first one
    always_comb begin
        plan.f0.off    = off;
        plan.f0.nbytes = n0;
        plan.f0.data   = wdata & lane_mask(n0);
        plan.f1.off    = 2'd0;
        plan.f1.nbytes = n1;
        plan.f1.data   = (wdata >> {n0[1:0], 3'b000}) & lane_mask(n1);
        plan.two       = two;
        plan.join_sh   = {n0[1:0], 3'b000};
    end

endmodule

// File: rtl/lws_memstore.sv
module lws_memstore #(
    parameter int WORDS = 512,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata
);
    logic [31:0] mem [WORDS];

    assign rdata = mem[idx];

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

endmodule

// File: rtl/lws_sequencer.sv
module lws_sequencer
    import lws_pkg::*;
#(
    parameter int AW = 12,
    localparam int IDX_W = AW - 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [AW-1:0]    req_next,
    input  plan_t            plan,
    output logic             busy,
    output logic             done,
    output logic [31:0]      rdata,
    output logic [IDX_W-1:0] mem_idx,
    output logic             mem_we,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    output logic             frag_valid,
    output logic             frag_we,
    output logic [AW-1:0]    frag_addr,
    output logic [1:0]       frag_off,
    output logic [2:0]       frag_bytes,
    output logic [31:0]      frag_wdata,
    input  logic [31:0]      frag_rdata
);
    localparam logic [AW-1:0] LOW_CLR = ~AW'(3);

    state_e        state;
    plan_t         plan_q;
    logic          wr_q;
    logic          sel_q;
    logic [AW-1:0] a0_q;
    logic [AW-1:0] a1_q;
    logic [31:0]   acc_q;
    logic [31:0]   lw_q;

    frag_t         cur;
    logic [AW-1:0] cur_a;
    logic          cur_reg;
    logic          cur_full;
    logic          last;
    logic [31:0]   piece;

    always_comb begin
        cur      = sel_q ? plan_q.f1 : plan_q.f0;
        cur_a    = sel_q ? a1_q : a0_q;
        cur_reg  = cur_a[AW-1];
        cur_full = (cur.nbytes == 3'd4);
        last     = !plan_q.two || sel_q;
        piece    = lane_extract(cur_reg ? frag_rdata : mem_rdata, cur.off, cur.nbytes);
    end

    // memory side: one cycle per piece, merged in place
    always_comb begin
        mem_idx   = cur_a[AW-2:2];
        mem_we    = (state == ST_FRAG) && !cur_reg && wr_q;
        mem_wdata = lane_merge(mem_rdata, cur.off, cur.nbytes, cur.data);
    end

    // register side: whole longwords only
    always_comb begin
        frag_valid = ((state == ST_FRAG) && cur_reg) || (state == ST_WBACK);
        frag_we    = ((state == ST_FRAG) && wr_q && cur_full) || (state == ST_WBACK);
        frag_addr  = cur_a;
        frag_off   = cur.off;
        frag_bytes = cur.nbytes;
        frag_wdata = (state == ST_WBACK) ? lane_merge(lw_q, cur.off, cur.nbytes, cur.data)
                                         : cur.data;
    end

    assign busy  = (state != ST_IDLE);
    assign done  = (state == ST_DONE);
    assign rdata = acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            plan_q <= '0;
            wr_q   <= 1'b0;
            sel_q  <= 1'b0;
            a0_q   <= '0;
            a1_q   <= '0;
            acc_q  <= '0;
            lw_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        plan_q <= plan;
                        wr_q   <= req_write;
                        a0_q   <= req_addr & LOW_CLR;
                        a1_q   <= req_next & LOW_CLR;
                        sel_q  <= 1'b0;
                        state  <= ST_FRAG;
                    end
                end
                ST_FRAG: begin
                    if (!wr_q) begin
                        acc_q <= sel_q ? (acc_q | (piece << plan_q.join_sh)) : piece;
                    end
                    if (cur_reg && wr_q && !cur_full) begin
                        lw_q  <= frag_rdata;
                        state <= ST_WBACK;
                    end else if (last) begin
                        state <= ST_DONE;
                    end else begin
                        sel_q <= 1'b1;
                    end
                end
                ST_WBACK: begin
                    if (last) begin
                        state <= ST_DONE;
                    end else begin
                        sel_q <= 1'b1;
                        state <= ST_FRAG;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3: every issued piece stays inside its longword
    assert_piece_fits_R3: assert property (@(posedge clk) disable iff (rst)
        frag_valid |-> (({2'b00, frag_off} + {1'b0, frag_bytes}) <= 4'd4));

    // R8: a partial register write is preceded by a read of the same longword
    assert_rmw_read_first_R8: assert property (@(posedge clk) disable iff (rst)
        (frag_valid && frag_we && (frag_bytes != 3'd4))
            |-> ($past(frag_valid && !frag_we) && $stable(frag_addr)));

    // R9: done lasts one cycle
    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: the captured access is held while busy
    assert_plan_held_R10: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(plan_q));

    // R6: a memory update never coincides with a register cycle
    assert_mem_excl_R6: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !frag_valid);

endmodule

// File: rtl/lw_splitter.sv
module lw_splitter
    import lws_pkg::*;
#(
    parameter int ADDR_W = 12,
    localparam int MEM_WORDS = 2 ** (ADDR_W - 3),
    localparam int IDX_W = ADDR_W - 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] req_next_addr,
    input  logic [31:0]       req_wdata,
    output logic              busy,
    output logic              done,
    output logic [31:0]       rdata,
    output logic              frag_valid,
    output logic              frag_we,
    output logic [ADDR_W-1:0] frag_addr,
    output logic [1:0]        frag_off,
    output logic [2:0]        frag_bytes,
    output logic [31:0]       frag_wdata,
    input  logic [31:0]       frag_rdata
);
    plan_t            plan;
    logic [IDX_W-1:0] mem_idx;
    logic             mem_we;
    logic [31:0]      mem_wdata;
    logic [31:0]      mem_rdata;

    lws_planner u_planner (
        .off   (req_addr[1:0]),
        .size  (req_size),
        .wdata (req_wdata),
        .plan  (plan)
    );

    lws_memstore #(.WORDS(MEM_WORDS)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .idx   (mem_idx),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    lws_sequencer #(.AW(ADDR_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_next   (req_next_addr),
        .plan       (plan),
        .busy       (busy),
        .done       (done),
        .rdata      (rdata),
        .mem_idx    (mem_idx),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .frag_valid (frag_valid),
        .frag_we    (frag_we),
        .frag_addr  (frag_addr),
        .frag_off   (frag_off),
        .frag_bytes (frag_bytes),
        .frag_wdata (frag_wdata),
        .frag_rdata (frag_rdata)
    );

    // R1: quiet right after reset
    assert_idle_after_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !done && !frag_valid));

    // R9: done only follows activity
    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

endmodule

// File: tb/lw_splitter_bench.sv
`timescale 1ns/100ps
module lw_splitter_bench;

    typedef struct packed {
        logic        we;
        logic [1:0]  sz;
        logic [11:0] a;
        logic [31:0] d;
        logic [3:0]  rq;
    } vec_t;

    // stimulus; expected data comes from the byte model below
    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd2, 12'h005, 32'h11223344, 4'd4},  // R4 long @1
        '{1'b0, 2'd2, 12'h005, 32'h0,        4'd3},  // R3
        '{1'b0, 2'd1, 12'h007, 32'h0,        4'd5},  // R5 word @3
        '{1'b1, 2'd1, 12'h00B, 32'h0000BEEF, 4'd5},
        '{1'b0, 2'd2, 12'h008, 32'h0,        4'd6},  // R6 neighbours
        '{1'b0, 2'd2, 12'h00C, 32'h0,        4'd6},
        '{1'b1, 2'd1, 12'h011, 32'h0000CAFE, 4'd5},  // word @1
        '{1'b0, 2'd2, 12'h010, 32'h0,        4'd6},
        '{1'b1, 2'd0, 12'h016, 32'h0000005A, 4'd6},
        '{1'b0, 2'd1, 12'h016, 32'h0,        4'd2},  // R2 word @2
        '{1'b1, 2'd3, 12'h01E, 32'h99887766, 4'd11}, // R11 code 3
        '{1'b0, 2'd2, 12'h01C, 32'h0,        4'd11},
        '{1'b0, 2'd2, 12'h020, 32'h0,        4'd11},
        '{1'b1, 2'd2, 12'h023, 32'hA1B2C3D4, 4'd4},
        '{1'b0, 2'd0, 12'h024, 32'h0,        4'd4},
        '{1'b0, 2'd3, 12'h022, 32'h0,        4'd11},
        '{1'b0, 2'd2, 12'h805, 32'h0,        4'd7},  // R7 register read
        '{1'b1, 2'd1, 12'h807, 32'h00001234, 4'd8},  // R8 partial writes
        '{1'b0, 2'd2, 12'h804, 32'h0,        4'd7},
        '{1'b0, 2'd2, 12'h808, 32'h0,        4'd7},
        '{1'b1, 2'd2, 12'h80C, 32'hDEADBEEF, 4'd8},  // full write
        '{1'b0, 2'd1, 12'h80D, 32'h0,        4'd7},
        '{1'b1, 2'd0, 12'h812, 32'h00000077, 4'd8},
        '{1'b0, 2'd2, 12'h810, 32'h0,        4'd8}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [11:0] req_addr = '0;
    logic [11:0] req_next_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        busy, done, frag_valid, frag_we;
    logic [31:0] rdata, frag_wdata, frag_rdata;
    logic [11:0] frag_addr;
    logic [1:0]  frag_off;
    logic [2:0]  frag_bytes;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    lw_splitter u_lw_splitter (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_next_addr(req_next_addr),
        .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
        .frag_valid(frag_valid), .frag_we(frag_we), .frag_addr(frag_addr),
        .frag_off(frag_off), .frag_bytes(frag_bytes), .frag_wdata(frag_wdata),
        .frag_rdata(frag_rdata)
    );

    // register space device and fragment log
    logic [31:0] dev [16];
    logic [11:0] ev_a [8];
    logic        ev_w [8];
    int          ev_n = 0;

    assign frag_rdata = dev[frag_addr[5:2]];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) dev[i] <= 32'hA0B0C0D0 + 32'h01010101 * i;
        end else if (frag_valid) begin
            ev_a[ev_n % 8] <= frag_addr;
            ev_w[ev_n % 8] <= frag_we;
            ev_n <= ev_n + 1;
            if (frag_we) dev[frag_addr[5:2]] <= frag_wdata;
        end
    end

    // expected byte model
    logic [7:0] mb [256];
    logic [7:0] rb [64];

    function automatic logic [7:0] get_b(input logic [11:0] a);
        return a[11] ? rb[a[5:0]] : mb[a[7:0]];
    endfunction

    function automatic logic [11:0] byte_at(input logic [11:0] a, input logic [11:0] nx,
                                            input int nb, input int i);
        int bo;
        bo = int'(a[1:0]);
        if (bo + nb > 4 && i >= 4 - bo) return (nx & 12'hFFC) + 12'(i - (4 - bo));
        return a + 12'(i);
    endfunction

    function automatic int cost(input logic [11:0] fa, input int n, input logic we);
        if (!fa[11]) return 1;
        return (we && n != 4) ? 2 : 1;
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic do_op(input logic we, input logic [1:0] sz, input logic [11:0] a,
                         input logic [11:0] nx, input logic [31:0] d, input string rq,
                         input bit intrude);
        int nb, bo, n0, n1, ec, ee, cyc, ev0;
        logic [31:0] exp_d;
        logic [11:0] ba;
        nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        bo = int'(a[1:0]);
        if (bo + nb > 4) begin n0 = 4 - bo; n1 = nb - n0; end
        else begin n0 = nb; n1 = 0; end
        ec = cost(a, n0, we) + ((n1 > 0) ? cost(nx, n1, we) : 0);
        ee = (a[11] ? cost(a, n0, we) : 0) + ((n1 > 0 && nx[11]) ? cost(nx, n1, we) : 0);
        exp_d = '0;
        for (int i = 0; i < nb; i++) exp_d[8*i +: 8] = get_b(byte_at(a, nx, nb, i));
        @(negedge clk);
        ev0 = ev_n;
        req_valid = 1'b1; req_write = we; req_size = sz;
        req_addr = a; req_next_addr = nx; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (intrude) begin
            req_valid = 1'b1; req_write = 1'b1; req_size = 2'd0;
            req_addr = 12'h030; req_next_addr = 12'h034; req_wdata = 32'h000000FF;
        end
        cyc = 0;
        while (!done && cyc < 40) begin
            cyc++;
            @(negedge clk);
            req_valid = 1'b0;
        end
        chk(cyc == ec, {rq, " R9 cycles"}, 32'(cyc), 32'(ec));
        chk((ev_n - ev0) == ee, {rq, " fragment cycles"}, 32'(ev_n - ev0), 32'(ee));
        if (!we) begin
            chk(rdata == exp_d, {rq, " read data"}, rdata, exp_d);
        end else begin
            for (int i = 0; i < nb; i++) begin
                ba = byte_at(a, nx, nb, i);
                if (ba[11]) rb[ba[5:0]] = d[8*i +: 8];
                else        mb[ba[7:0]] = d[8*i +: 8];
            end
            for (int k = 0; k < 16; k++) begin
                logic [31:0] e;
                e = {rb[4*k+3], rb[4*k+2], rb[4*k+1], rb[4*k]};
                if (dev[k] != e) chk(1'b0, {rq, " R8 register contents"}, dev[k], e);
            end
            n_chk++;
        end
        @(negedge clk);
        chk(!done, {rq, " R9 done width"}, 32'(done), 32'd0);
    endtask

    function automatic logic [11:0] nxt(input logic [11:0] a);
        return (a & 12'hFFC) + 12'h004;
    endfunction

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int e0;
        for (int i = 0; i < 16; i++) begin
            logic [31:0] v;
            v = 32'hA0B0C0D0 + 32'h01010101 * i;
            for (int b = 0; b < 4; b++) rb[4*i+b] = v[8*b +: 8];
        end
        for (int i = 0; i < 256; i++) mb[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !frag_valid, "R1 reset outputs",
            {29'd0, busy, done, frag_valid}, 32'd0);

        // R2 aligned longword writes fill the memory region
        for (int k = 0; k < 16; k++)
            do_op(1'b1, 2'd2, 12'(4*k), nxt(12'(4*k)), 32'h10203040 + 32'h04040404 * k,
                  "R2 aligned fill", 1'b0);
        do_op(1'b1, 2'd2, 12'h080, 12'h084, 32'h55667788, "R2 aligned fill", 1'b0);
        do_op(1'b0, 2'd2, 12'h014, 12'h018, 32'h0, "R2 aligned read", 1'b0);
        do_op(1'b0, 2'd0, 12'h013, 12'h014, 32'h0, "R2 byte read", 1'b0);

        for (int i = 0; i < NV; i++)
            do_op(VECS[i].we, VECS[i].sz, VECS[i].a, nxt(VECS[i].a), VECS[i].d,
                  $sformatf("R%0d vec%0d", VECS[i].rq, i), 1'b0);

        // R3 second piece goes to a translated, non-adjacent longword
        do_op(1'b1, 2'd2, 12'h03D, 12'h082, 32'hF1E2D3C4, "R3 translated write", 1'b0);
        do_op(1'b0, 2'd2, 12'h03D, 12'h080, 32'h0, "R3 translated read", 1'b0);
        do_op(1'b0, 2'd2, 12'h080, 12'h084, 32'h0, "R3 next longword", 1'b0);
        do_op(1'b0, 2'd2, 12'h03C, 12'h040, 32'h0, "R3 first longword", 1'b0);

        // R9 order and R8 read-before-write on a crossing register word
        e0 = ev_n;
        do_op(1'b1, 2'd1, 12'h81B, nxt(12'h81B), 32'h0000ABCD, "R8 cross word", 1'b0);
        chk(ev_a[e0 % 8] == 12'h818 && !ev_w[e0 % 8], "R9 order 1",
            {19'd0, ev_w[e0 % 8], ev_a[e0 % 8]}, 32'h818);
        chk(ev_a[(e0 + 1) % 8] == 12'h818 && ev_w[(e0 + 1) % 8], "R8 order 2",
            {19'd0, ev_w[(e0 + 1) % 8], ev_a[(e0 + 1) % 8]}, 32'h1818);
        chk(ev_a[(e0 + 2) % 8] == 12'h81C && !ev_w[(e0 + 2) % 8], "R9 order 3",
            {19'd0, ev_w[(e0 + 2) % 8], ev_a[(e0 + 2) % 8]}, 32'h81C);
        chk(ev_a[(e0 + 3) % 8] == 12'h81C && ev_w[(e0 + 3) % 8], "R8 order 4",
            {19'd0, ev_w[(e0 + 3) % 8], ev_a[(e0 + 3) % 8]}, 32'h181C);

        // R10 a request raised while busy is dropped
        do_op(1'b0, 2'd2, 12'h005, 12'h008, 32'h0, "R10 busy read", 1'b1);
        chk(!busy, "R10 idle after", {31'd0, busy}, 32'd0);
        do_op(1'b0, 2'd0, 12'h030, 12'h034, 32'h0, "R10 untouched byte", 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule